// File: doc/BRIEF.md
# Rewindable Packet FIFO

This block is a synchronous, word-wide FIFO for framed traffic such as Ethernet. Each side keeps a live pointer and a saved pointer. The producer pushes words and then either commits them, which makes the packet visible to the consumer, or abandons them, which rolls its live pointer back to the last commit point. The consumer pops words in show-ahead fashion. Once a packet has gone out safely, it releases the words so their slots can be reused. If the packet has to be sent again, it rewinds to the last release point and reads the packet a second time.

Free space is measured from the consumer's saved pointer, so words that have been read but not released cannot be overwritten. Readable data is measured up to the producer's saved pointer, so the consumer never sees a partial packet. The block reports occupancy (committed words not yet read) and vacancy (free slots) in words, along with empty, full, almost-empty, almost-full and a deadlock flag. A deadlock exists when the store is full and empty at the same moment. This happens when one uncommitted packet fills every slot. The deadlock raises an error interrupt that stays set until reset. Reset discards all data and clears every pointer, count and flag.

Top module: `pkt_fifo_rewind`

## Requirements
- R1: While and after reset, occupancy is 0, vacancy equals the depth (16 by default), empty is 1, and full, almost-empty, almost-full, deadlock and the interrupt are 0.
- R2: Words come out in the order they were pushed. The read data port shows the word at the live read pointer whenever the FIFO is not empty.
- R3: Vacancy equals the depth minus the words between the read saved pointer and the live write pointer. Full is 1 when vacancy is 0, and a push while full is ignored.
- R4: Occupancy equals the committed words not yet read, and empty is 1 when occupancy is 0. A pop while empty is ignored, and uncommitted words are never readable.
- R5: A commit pulse copies the write pointer, including a word pushed in the same cycle, into the write saved pointer. Occupancy reflects this from the next cycle.
- R6: A write-abandon pulse returns the write pointer to the write saved pointer. It overrides a push or a commit in the same cycle, both of which are then ignored.
- R7: A release pulse copies the read pointer, including a word popped in the same cycle, into the read saved pointer. The freed slots appear in vacancy from the next cycle.
- R8: A read-rewind pulse returns the read pointer to the read saved pointer, so the words are read again in the same order. A pop or release in the same cycle is ignored.
- R9: Almost-empty is 1 exactly when occupancy is 1, and almost-full is 1 exactly when vacancy is 1.
- R10: Deadlock is 1 exactly when full and empty are both 1. The interrupt sets in the cycle after deadlock is seen and stays set until reset.
- R11: Reset during traffic discards all contents and clears the interrupt, returning every output to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Push one word |
| wr_data_i | input | 32 | Word to push |
| wr_commit_i | input | 1 | Commit the packet written so far |
| wr_abort_i | input | 1 | Drop the uncommitted words |
| rd_en_i | input | 1 | Pop one word |
| rd_data_o | output | 32 | Word at the live read pointer (show-ahead) |
| rd_release_i | input | 1 | Free the words read so far |
| rd_rewind_i | input | 1 | Return the read pointer to the release point |
| occupancy_o | output | 5 | Committed words not yet read |
| vacancy_o | output | 5 | Free word slots |
| empty_o | output | 1 | Occupancy is zero |
| full_o | output | 1 | Vacancy is zero |
| almost_empty_o | output | 1 | Occupancy is one |
| almost_full_o | output | 1 | Vacancy is one |
| deadlock_o | output | 1 | Full and empty at once |
| err_irq_o | output | 1 | Sticky error interrupt raised by deadlock |

## Verification
The hardest state to reach is deadlock. Getting there needs the consumer to have released everything while the producer fills all slots without one commit. Random traffic rarely produces that, so a directed phase drains the FIFO, releases it, and pushes exactly depth words with no commit. It then abandons the packet, to show that the flag drops while the interrupt stays set. A reset then clears the interrupt. The random phase makes commits rare and releases frequent, so long uncommitted packets still build up. It also mixes abandon, rewind and release pulses with same-cycle pushes and pops, and each cycle is compared against a queue-based model.

// File: rtl/pktf_pkg.sv
package pktf_pkg;
    // Per-cycle command for one side's pointer pair.
    typedef struct packed {
        logic step;  // advance live pointer by one word
        logic save;  // copy (advanced) live pointer into saved pointer
        logic back;  // return live pointer to saved pointer, overrides the rest
    } ptr_cmd_t;
endpackage

// File: rtl/pktf_ptr_ctl.sv
module pktf_ptr_ctl
    import pktf_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  ptr_cmd_t      cmd_i,
    input  logic          hold_i,
    output logic [PW-1:0] ptr_o,
    output logic [PW-1:0] mark_o,
    output logic          adv_o
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] mark;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        adv_o = cmd_i.step & ~hold_i & ~cmd_i.back;
        if (cmd_i.back) begin
            st_d.ptr = st_q.mark;
        end else begin
            st_d.ptr = st_q.ptr + {{(PW-1){1'b0}}, adv_o};
            if (cmd_i.save) begin
                st_d.mark = st_d.ptr;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o  = st_q.ptr;
    assign mark_o = st_q.mark;

    // R6 / R8: a back pulse lands the live pointer on the saved one
    p_back_to_mark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i.back |=> (ptr_o == $past(mark_o)));

    // R6 / R8: a back pulse leaves the saved pointer alone
    p_back_keeps_mark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i.back |=> $stable(mark_o));
endmodule

// File: rtl/pktf_store.sv
module pktf_store #(
    parameter int DATA_W = 32,
    parameter int AW     = 4
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int SLOTS = 1 << AW;

    logic [DATA_W-1:0] mem_q [SLOTS];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pktf_status.sv
module pktf_status #(
    parameter int AW = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [AW:0] wr_ptr_i,
    input  logic [AW:0] wr_mark_i,
    input  logic [AW:0] rd_ptr_i,
    input  logic [AW:0] rd_mark_i,
    output logic [AW:0] occupancy_o,
    output logic [AW:0] vacancy_o,
    output logic        empty_o,
    output logic        full_o,
    output logic        almost_empty_o,
    output logic        almost_full_o,
    output logic        deadlock_o,
    output logic        err_irq_o
);
    localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

    logic [AW:0] held;
    logic        irq_d, irq_q;

    always_comb begin
        held           = wr_ptr_i - rd_mark_i;
        occupancy_o    = wr_mark_i - rd_ptr_i;
        vacancy_o      = CAP - held;
        full_o         = (held == CAP);
        empty_o        = (occupancy_o == '0);
        almost_empty_o = (occupancy_o == ONE);
        almost_full_o  = (vacancy_o == ONE);
        deadlock_o     = full_o & empty_o;
        irq_d          = irq_q | deadlock_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign err_irq_o = irq_q;

    p_irq_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_irq_o |=> err_irq_o);

    p_deadlock_raises_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        deadlock_o |=> err_irq_o);
endmodule

// File: rtl/pkt_fifo_rewind.sv
module pkt_fifo_rewind
    import pktf_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic                  wr_commit_i,
    input  logic                  wr_abort_i,
    input  logic                  rd_en_i,
    output logic [DATA_W-1:0]     rd_data_o,
    input  logic                  rd_release_i,
    input  logic                  rd_rewind_i,
    output logic [DEPTH_LOG2:0]   occupancy_o,
    output logic [DEPTH_LOG2:0]   vacancy_o,
    output logic                  empty_o,
    output logic                  full_o,
    output logic                  almost_empty_o,
    output logic                  almost_full_o,
    output logic                  deadlock_o,
    output logic                  err_irq_o
);
    localparam int          AW  = DEPTH_LOG2;
    localparam int          PW  = AW + 1;
    localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};

    ptr_cmd_t      wr_cmd, rd_cmd;
    logic [PW-1:0] wr_ptr, wr_mark, rd_ptr, rd_mark;
    logic          wr_adv, rd_adv;

    assign wr_cmd = '{step: wr_en_i, save: wr_commit_i, back: wr_abort_i};
    assign rd_cmd = '{step: rd_en_i, save: rd_release_i, back: rd_rewind_i};

    pktf_ptr_ctl #(.PW(PW)) u_wr_side (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cmd_i  (wr_cmd),
        .hold_i (full_o),
        .ptr_o  (wr_ptr),
        .mark_o (wr_mark),
        .adv_o  (wr_adv)
    );

    pktf_ptr_ctl #(.PW(PW)) u_rd_side (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cmd_i  (rd_cmd),
        .hold_i (empty_o),
        .ptr_o  (rd_ptr),
        .mark_o (rd_mark),
        .adv_o  (rd_adv)
    );

    pktf_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
        .clk_i   (clk_i),
        .we_i    (wr_adv),
        .waddr_i (wr_ptr[AW-1:0]),
        .wdata_i (wr_data_i),
        .raddr_i (rd_ptr[AW-1:0]),
        .rdata_o (rd_data_o)
    );

    pktf_status #(.AW(AW)) u_status (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .wr_ptr_i       (wr_ptr),
        .wr_mark_i      (wr_mark),
        .rd_ptr_i       (rd_ptr),
        .rd_mark_i      (rd_mark),
        .occupancy_o    (occupancy_o),
        .vacancy_o      (vacancy_o),
        .empty_o        (empty_o),
        .full_o         (full_o),
        .almost_empty_o (almost_empty_o),
        .almost_full_o  (almost_full_o),
        .deadlock_o     (deadlock_o),
        .err_irq_o      (err_irq_o)
    );

    // R3: the producer never holds more than the capacity past the release point
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (PW'(wr_ptr - rd_mark) <= CAP));

    // R4: the consumer never runs past the commit point
    p_no_overread_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (PW'(rd_ptr - rd_mark) <= PW'(wr_mark - rd_mark)));

    // R4: an accepted pop never happens on an empty FIFO
    p_pop_not_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_adv |-> !empty_o);
endmodule

// File: tb/pkt_fifo_rewind_tb.sv
module pkt_fifo_rewind_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_commit, wr_abort, rd_en, rd_release, rd_rewind;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [4:0]  occupancy, vacancy;
    logic        empty, full, a_empty, a_full, deadlock, err_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_fifo_rewind dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .wr_en_i        (wr_en),
        .wr_data_i      (wr_data),
        .wr_commit_i    (wr_commit),
        .wr_abort_i     (wr_abort),
        .rd_en_i        (rd_en),
        .rd_data_o      (rd_data),
        .rd_release_i   (rd_release),
        .rd_rewind_i    (rd_rewind),
        .occupancy_o    (occupancy),
        .vacancy_o      (vacancy),
        .empty_o        (empty),
        .full_o         (full),
        .almost_empty_o (a_empty),
        .almost_full_o  (a_full),
        .deadlock_o     (deadlock),
        .err_irq_o      (err_irq)
    );

    // Reference model: queue holds words from the release point onward.
    logic [31:0] mq[$];
    int m_rd;    // live read offset from release point
    int m_cm;    // committed words from release point
    bit m_irq;
    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R1 reset";
    bit done = 0;

    function automatic void model_reset();
        mq.delete();
        m_rd = 0;
        m_cm = 0;
        m_irq = 0;
    endfunction

    function automatic void model_update();
        bit pre_full, pre_empty;
        if (!rst_n) begin
            model_reset();
            return;
        end
        pre_full  = (mq.size() == DEPTH);
        pre_empty = (m_rd == m_cm);
        if (pre_full && pre_empty) m_irq = 1;
        // write side
        if (wr_abort) begin
            while (mq.size() > m_cm) void'(mq.pop_back());
        end else begin
            if (wr_en && !pre_full) mq.push_back(wr_data);
            if (wr_commit) m_cm = mq.size();
        end
        // read side
        if (rd_rewind) begin
            m_rd = 0;
        end else begin
            if (rd_en && !pre_empty) m_rd++;
            if (rd_release) begin
                for (int i = 0; i < m_rd; i++) void'(mq.pop_front());
                m_cm -= m_rd;
                m_rd = 0;
            end
        end
    endfunction

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s: got %0h expected %0h", phase, what, got, exp);
        end
    endtask

    task automatic compare();
        int  occ, vac;
        bit  e_full, e_empty;
        occ     = m_cm - m_rd;
        vac     = DEPTH - mq.size();
        e_full  = (vac == 0);
        e_empty = (occ == 0);
        chk("R4 occupancy", 32'(occupancy), 32'(occ));
        chk("R3 vacancy", 32'(vacancy), 32'(vac));
        chk("R4 empty", 32'(empty), 32'(e_empty));
        chk("R3 full", 32'(full), 32'(e_full));
        chk("R9 almost_empty", 32'(a_empty), 32'(occ == 1));
        chk("R9 almost_full", 32'(a_full), 32'(vac == 1));
        chk("R10 deadlock", 32'(deadlock), 32'(e_full && e_empty));
        chk("R10 err_irq", 32'(err_irq), 32'(m_irq));
        if (!e_empty) chk("R2 read data", rd_data, mq[m_rd]);
    endtask

    task automatic step(input bit we, input bit wc, input bit wa,
                        input bit re, input bit rl, input bit rr);
        wr_en = we; wr_commit = wc; wr_abort = wa;
        rd_en = re; rd_release = rl; rd_rewind = rr;
        wr_data = $urandom;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL [watchdog] run did not finish: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        wr_en = 0; wr_commit = 0; wr_abort = 0; wr_data = '0;
        rd_en = 0; rd_release = 0; rd_rewind = 0;
        model_reset();
        @(negedge clk);
        compare();                       // R1 during reset
        step(1, 1, 0, 1, 1, 0);          // R1: ignored while in reset
        rst_n = 1;
        step(0, 0, 0, 0, 0, 0);          // R1 after release of reset

        phase = "R2 R5 commit and order";
        for (int i = 0; i < 5; i++) step(1, i == 4, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 0);

        phase = "R4 uncommitted invisible";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, 0);
        step(0, 1, 0, 1, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, 0);

        phase = "R6 abandon";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
        step(1, 1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0);

        phase = "R7 R8 rewind and release";
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 1, 1);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, i == 3, 0);

        phase = "R3 R9 fill to full";
        for (int i = 0; i < DEPTH + 3; i++) step(1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 1, 0);

        phase = "R10 deadlock";
        for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);

        phase = "R11 reset mid traffic";
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0, 0);
        rst_n = 0;
        step(0, 0, 0, 0, 0, 0);
        rst_n = 1;
        step(0, 0, 0, 0, 0, 0);

        phase = "random R2 R3 R4 R5 R6 R7 R8 R9 R10";
        for (int i = 0; i < 6000; i++) begin
            rst_n = ($urandom_range(0, 799) != 0);
            step($urandom_range(0, 99) < 60,
                 $urandom_range(0, 99) < 8,
                 $urandom_range(0, 99) < 3,
                 $urandom_range(0, 99) < 50,
                 $urandom_range(0, 99) < 30,
                 $urandom_range(0, 99) < 4);
        end
        rst_n = 1;
        done = 1;
        summary();
        $finish;
    end
endmodule